// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block sits on the host side of an external, asynchronous parallel ROM that offers a fast page read. It turns read requests (start address plus a burst length) into chip-enable, output-enable, mode-select and address activity on the ROM pins. Because the ROM has no clock, every access time is converted to a whole number of system clock cycles. The returned data leaves as a stream of single-cycle valid beats.

The controller remembers which page is open in the ROM. A page is eight 16-bit words, or sixteen bytes. A read that lands in the open page waits only the short page time. A read that opens a new page waits the full random-access time, as does the first read after standby or after a width change. In byte mode the top data pin of the ROM becomes the lowest address input. The controller then drives it, and only the low data lane is used. After a burst, output-enable stays high for a turnaround period so the ROM's drivers can release the bus. After a run of idle cycles, chip-enable is raised to put the ROM in standby, and the open page is forgotten.

Access times are parameters in picoseconds together with the clock period. Cycle counts are the rounded-up quotients: with a 4 ns clock these are 25 cycles random, 8 page, 8 output-enable and 5 turnaround.

Top module: `prom_page_reader`

## Requirements
- R1: Out of reset, `romCeN` and `romOeN` are high, `rdValid` is low and `reqReady` is high.
- R2: A request is taken on a clock edge where `reqValid` and `reqReady` are both high. It yields `reqLen`+1 beats from sequential locations. In the cycle after acceptance, `romAddr`/`romAm1` show the start location.
- R3: When the first beat of a request opens a new page, it is captured on the edge that ends cycle RAND (25) after acceptance. A new page means a different page tag, a width change, or the first beat after standby or reset. `rdValid` is high in the cycle after that edge.
- R4: A later beat of a burst that stays in the open page is captured PAGE (8) cycles after the previous capture.
- R5: A first beat that hits the open page waits max(PAGE, OE) cycles, so output-enable always has at least OE cycles before capture.
- R6: When a burst steps across a page boundary, or wraps past the top of memory, that beat waits RAND cycles.
- R7: With `reqByte`=1, `reqAddr` is a byte address. Its bit 0 drives `romAm1` with `romAm1En`=1 and `romByteN`=0. The location steps by one byte, and `rdData` = {8'h00, romData[7:0]}, ignoring romData[15:8].
- R8: With `reqByte`=0, `reqAddr[18:0]` is a word address and `reqAddr[19]` is ignored. `romByteN`=1, `romAm1En`=0, and `rdData` is the full 16-bit bus.
- R9: During a burst, chip-enable and output-enable stay low. The address is held stable between captures and changes only on a capture edge.
- R10: After the last beat is captured, `romOeN` goes high and `reqReady` stays low for TURN (5) cycles. `reqReady` rises TURN cycles after the cycle in which `rdLast` is seen.
- R11: After IDLE (32) consecutive idle cycles with chip-enable low, `romCeN` goes high and the next read is treated as a page miss. A shorter idle gap keeps the page open.
- R12: `rdValid` pulses once per beat, and `rdLast` is high only with the final beat of a request.
- R13: `romOeN` is never low while `romCeN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Read request present |
| reqReady | output | 1 | Controller can accept a request |
| reqAddr | input | ADDR_W+1 (20) | Start address: byte address in byte mode, word address in bits [18:0] in word mode |
| reqLen | input | LEN_W (5) | Number of beats minus one |
| reqByte | input | 1 | 1 selects 8-bit byte mode for this request |
| romAddr | output | ADDR_W (19) | ROM word address pins |
| romAm1 | output | 1 | Lowest byte address bit, driven onto the top data pin in byte mode |
| romAm1En | output | 1 | Drive enable for `romAm1` |
| romCeN | output | 1 | ROM chip enable, active low |
| romOeN | output | 1 | ROM output enable, active low |
| romByteN | output | 1 | ROM width select: 1 word, 0 byte |
| romData | input | 16 | ROM data bus |
| rdValid | output | 1 | Captured data beat valid |
| rdData | output | 16 | Captured data |
| rdLast | output | 1 | Final beat of the request |

## Verification
The bound checker watches, on every cycle, the pin-level rules that hold in any scenario. These are output-enable never low without chip-enable, the address held between captures, both enables low right after acceptance, readiness only with output-enable high, and last only with valid. The cycle at which each beat appears is observed only by the bench. So are the split between page hits and misses (including page crossings, wraps, width changes and standby), the byte-lane selection and the turnaround length. The bench's ROM model returns a poison value whenever the ROM's timing is not met, so a capture one cycle early shows up as a data miscompare.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_TURN   = 2'd2
  } rdState_e;

  // Strobes from the sequencer to the address / capture datapath.
  typedef struct packed {
    logic loadAddr;   // take the request start location
    logic stepAddr;   // advance to the next sequential location
    logic capture;    // sample the ROM bus this edge
    logic lastBeat;   // the capture is the final one of the request
    logic closePage;  // standby entry, forget the open page
  } rdStrobe_t;

endpackage

// File: rtl/prom_rd_ctrl.sv
module prom_rd_ctrl
  import prom_rd_pkg::*;
#(
  parameter int LEN_W      = 5,
  parameter int CNT_W      = 6,
  parameter int IDLE_W     = 6,
  parameter int RAND_CYC   = 25,
  parameter int PAGE_CYC   = 8,
  parameter int FMISS_CYC  = 25,
  parameter int FHIT_CYC   = 8,
  parameter int TURN_CYC   = 5,
  parameter int IDLE_CYC   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             hitLoad,
  input  logic             hitStep,
  output rdStrobe_t        strb,
  output logic             romCeN,
  output logic             romOeN
);

  localparam logic [CNT_W-1:0]  RAND_LD  = CNT_W'(RAND_CYC - 1);
  localparam logic [CNT_W-1:0]  PAGE_LD  = CNT_W'(PAGE_CYC - 1);
  localparam logic [CNT_W-1:0]  FMISS_LD = CNT_W'(FMISS_CYC - 1);
  localparam logic [CNT_W-1:0]  FHIT_LD  = CNT_W'(FHIT_CYC - 1);
  localparam logic [CNT_W-1:0]  TURN_LD  = CNT_W'(TURN_CYC - 1);
  localparam logic [IDLE_W-1:0] IDLE_END = IDLE_W'(IDLE_CYC - 1);

  rdState_e          state;
  logic [CNT_W-1:0]  cnt;
  logic [LEN_W-1:0]  beatsLeft;
  logic [IDLE_W-1:0] idleCnt;
  logic              ceN;
  logic              oeN;

  assign romCeN = ceN;
  assign romOeN = oeN;

  always_comb begin
    reqReady       = (state == ST_IDLE);
    strb           = '0;
    strb.loadAddr  = reqReady && reqValid;
    strb.capture   = (state == ST_ACCESS) && (cnt == '0);
    strb.stepAddr  = strb.capture && (beatsLeft != '0);
    strb.lastBeat  = strb.capture && (beatsLeft == '0);
    strb.closePage = reqReady && !reqValid && !ceN && (idleCnt == IDLE_END);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      beatsLeft <= '0;
      idleCnt   <= '0;
      ceN       <= 1'b1;
      oeN       <= 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.loadAddr) begin
            ceN       <= 1'b0;
            oeN       <= 1'b0;
            cnt       <= hitLoad ? FHIT_LD : FMISS_LD;
            beatsLeft <= reqLen;
            idleCnt   <= '0;
            state     <= ST_ACCESS;
          end else if (strb.closePage) begin
            ceN     <= 1'b1;
            idleCnt <= '0;
          end else if (!ceN) begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        ST_ACCESS: begin
          if (!strb.capture) begin
            cnt <= cnt - 1'b1;
          end else if (strb.stepAddr) begin
            beatsLeft <= beatsLeft - 1'b1;
            cnt       <= hitStep ? PAGE_LD : RAND_LD;
          end else begin
            oeN   <= 1'b1;
            cnt   <= TURN_LD;
            state <= ST_TURN;
          end
        end
        ST_TURN: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/prom_rd_dpath.sv
module prom_rd_dpath
  import prom_rd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strb,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic              reqByte,
  input  logic [15:0]       romData,
  output logic              hitLoad,
  output logic              hitStep,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romAm1,
  output logic              romAm1En,
  output logic              romByteN,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic              rdLast
);

  // Location is kept at byte granularity in both widths.
  localparam int CUR_W = ADDR_W + 1;
  localparam int TAG_W = ADDR_W - PAGE_W;

  logic [CUR_W-1:0] cursor;
  logic [CUR_W-1:0] reqCursor;
  logic [CUR_W-1:0] nextCursor;
  logic [TAG_W-1:0] openTag;
  logic             pageValid;
  logic             byteMode;
  logic [15:0]      laneData;

  function automatic logic [TAG_W-1:0] tagOf(input logic [CUR_W-1:0] loc);
    return loc[CUR_W-1 -: TAG_W];
  endfunction

  always_comb begin
    reqCursor  = reqByte ? reqAddr : {reqAddr[ADDR_W-1:0], 1'b0};
    nextCursor = cursor + (byteMode ? CUR_W'(1) : CUR_W'(2));
    hitLoad    = pageValid && (byteMode == reqByte) && (tagOf(reqCursor) == openTag);
    hitStep    = pageValid && (tagOf(nextCursor) == openTag);
    laneData   = byteMode ? {8'h00, romData[7:0]} : romData;
  end

  assign romAddr  = cursor[CUR_W-1:1];
  assign romAm1   = cursor[0];
  assign romAm1En = byteMode;
  assign romByteN = !byteMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cursor    <= '0;
      openTag   <= '0;
      pageValid <= 1'b0;
      byteMode  <= 1'b0;
    end else if (strb.loadAddr) begin
      cursor    <= reqCursor;
      openTag   <= tagOf(reqCursor);
      pageValid <= 1'b1;
      byteMode  <= reqByte;
    end else if (strb.stepAddr) begin
      cursor  <= nextCursor;
      openTag <= tagOf(nextCursor);
    end else if (strb.closePage) begin
      pageValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdLast  <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.capture;
      rdLast  <= strb.lastBeat;
      if (strb.capture) rdData <= laneData;
    end
  end

endmodule

// File: rtl/prom_page_reader.sv
module prom_page_reader
  import prom_rd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int LEN_W    = 5,
  parameter int CLK_PS   = 4000,
  parameter int RAND_PS  = 100000,
  parameter int PAGE_PS  = 30000,
  parameter int OE_PS    = 30000,
  parameter int HZ_PS    = 20000,
  parameter int IDLE_CYC = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W:0]   reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              reqByte,
  output logic [ADDR_W-1:0] romAddr,
  output logic              romAm1,
  output logic              romAm1En,
  output logic              romCeN,
  output logic              romOeN,
  output logic              romByteN,
  input  logic [15:0]       romData,
  output logic              rdValid,
  output logic [15:0]       rdData,
  output logic              rdLast
);

  localparam int PAGE_W    = 3;
  localparam int RAND_RAW  = (RAND_PS + CLK_PS - 1) / CLK_PS;
  localparam int PAGE_RAW  = (PAGE_PS + CLK_PS - 1) / CLK_PS;
  localparam int OE_RAW    = (OE_PS + CLK_PS - 1) / CLK_PS;
  localparam int TURN_RAW  = (HZ_PS + CLK_PS - 1) / CLK_PS;
  localparam int RAND_CYC  = (RAND_RAW < 1) ? 1 : RAND_RAW;
  localparam int PAGE_CYC  = (PAGE_RAW < 1) ? 1 : PAGE_RAW;
  localparam int OE_CYC    = (OE_RAW < 1) ? 1 : OE_RAW;
  localparam int TURN_CYC  = (TURN_RAW < 1) ? 1 : TURN_RAW;
  localparam int FMISS_CYC = (RAND_CYC > OE_CYC) ? RAND_CYC : OE_CYC;
  localparam int FHIT_CYC  = (PAGE_CYC > OE_CYC) ? PAGE_CYC : OE_CYC;
  localparam int CNT_MAX   = (FMISS_CYC > TURN_CYC) ? FMISS_CYC : TURN_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int IDLE_W    = $clog2(IDLE_CYC + 1);

  rdStrobe_t strb;
  logic      hitLoad;
  logic      hitStep;

  prom_rd_ctrl #(
    .LEN_W    (LEN_W),
    .CNT_W    (CNT_W),
    .IDLE_W   (IDLE_W),
    .RAND_CYC (RAND_CYC),
    .PAGE_CYC (PAGE_CYC),
    .FMISS_CYC(FMISS_CYC),
    .FHIT_CYC (FHIT_CYC),
    .TURN_CYC (TURN_CYC),
    .IDLE_CYC (IDLE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .reqLen  (reqLen),
    .hitLoad (hitLoad),
    .hitStep (hitStep),
    .strb    (strb),
    .romCeN  (romCeN),
    .romOeN  (romOeN)
  );

  prom_rd_dpath #(
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqByte (reqByte),
    .romData (romData),
    .hitLoad (hitLoad),
    .hitStep (hitStep),
    .romAddr (romAddr),
    .romAm1  (romAm1),
    .romAm1En(romAm1En),
    .romByteN(romByteN),
    .rdValid (rdValid),
    .rdData  (rdData),
    .rdLast  (rdLast)
  );

endmodule

// File: rtl/prom_page_reader_chk.sv
module prom_page_reader_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              romCeN,
  input logic              romOeN,
  input logic [ADDR_W-1:0] romAddr,
  input logic              romAm1,
  input logic              rdValid,
  input logic              rdLast
);

  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rstN)
    !romOeN |-> !romCeN); // R13

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!romOeN && $past(!romOeN) && !rdValid) |-> ($stable(romAddr) && $stable(romAm1))); // R9

  AST_ACCEPT_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!romCeN && !romOeN)); // R2

  AST_READY_OE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> romOeN); // R10

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    rdLast |-> rdValid); // R12

  AST_NO_BEAT_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !reqReady); // R12

endmodule

bind prom_page_reader prom_page_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .romCeN  (romCeN),
  .romOeN  (romOeN),
  .romAddr (romAddr),
  .romAm1  (romAm1),
  .rdValid (rdValid),
  .rdLast  (rdLast)
);

// File: tb/prom_page_reader_bench.sv
module prom_page_reader_bench;

  localparam int B_RAND = (100000 + 3999) / 4000;
  localparam int B_PAGE = (30000 + 3999) / 4000;
  localparam int B_OE   = (30000 + 3999) / 4000;
  localparam int B_TURN = (20000 + 3999) / 4000;
  localparam int B_IDLE = 32;
  localparam int B_FMISS = (B_RAND > B_OE) ? B_RAND : B_OE;
  localparam int B_FHIT  = (B_PAGE > B_OE) ? B_PAGE : B_OE;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [19:0] reqAddr = '0;
  logic [4:0]  reqLen = '0;
  logic        reqByte = 1'b0;
  logic [18:0] romAddr;
  logic        romAm1, romAm1En, romCeN, romOeN, romByteN;
  logic [15:0] romData;
  logic        rdValid, rdLast;
  logic [15:0] rdData;

  always #2 clk = ~clk;

  prom_page_reader u_prom_page_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqByte(reqByte),
    .romAddr(romAddr), .romAm1(romAm1), .romAm1En(romAm1En),
    .romCeN(romCeN), .romOeN(romOeN), .romByteN(romByteN), .romData(romData),
    .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast)
  );

  function automatic logic [15:0] romWord(input logic [18:0] wa);
    return wa[15:0] ^ {wa[18:16], wa[18:16], 10'h000} ^ 16'hC35A;
  endfunction

  // Behavioural ROM: poison value unless every access time has elapsed.
  logic [19:0] mLoc;
  logic [19:0] prevLoc = '0;
  logic        prevMode = 1'b0;
  int          prevA = 0, prevP = 0, prevO = 0;
  int          curA, curP, curO;
  logic [15:0] mWord;

  assign mLoc = {romAddr, romByteN ? 1'b0 : romAm1};

  always_comb begin
    curA = romCeN ? 0 : ((mLoc == prevLoc && romByteN == prevMode && prevA > 0)
                         ? ((prevA < 1000) ? prevA + 1 : prevA) : 1);
    curP = romCeN ? 0 : ((mLoc[19:4] == prevLoc[19:4] && romByteN == prevMode && prevP > 0)
                         ? ((prevP < 1000) ? prevP + 1 : prevP) : 1);
    curO = (romCeN || romOeN) ? 0 : ((prevO < 1000) ? prevO + 1 : prevO);
    mWord = romWord(mLoc[19:1]);
    if (!romCeN && !romOeN && curO >= B_OE && curP >= B_RAND && curA >= B_PAGE)
      romData = romByteN ? mWord : {8'hA5, mLoc[0] ? mWord[15:8] : mWord[7:0]};
    else
      romData = 16'hDEAD;
  end

  always @(posedge clk) begin
    prevA <= curA; prevP <= curP; prevO <= curO;
    prevLoc <= mLoc; prevMode <= romByteN;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Expected beat queue.
  logic [15:0] expData [64];
  int          expCyc  [64];
  logic        expLast [64];
  string       expTReq [64];
  string       expDReq [64];
  int head = 0, tail = 0, lastCyc = 0;

  // Bench view of the open page.
  bit          bOpen = 0;
  logic [15:0] bTag = '0;
  logic        bMode = 1'b0;

  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (head == tail) begin
        chk(1'b0, "R12", 32'(rdData), 32'hFFFF);
      end else begin
        chk(rdData == expData[head], expDReq[head], 32'(rdData), 32'(expData[head]));
        chk(cyc == expCyc[head], expTReq[head], 32'(cyc), 32'(expCyc[head]));
        chk(rdLast == expLast[head], "R12", 32'(rdLast), 32'(expLast[head]));
        if (rdLast) lastCyc = cyc;
        head = (head + 1) % 64;
      end
    end
  end

  task automatic doBurst(input bit m, input logic [19:0] a, input int len);
    logic [19:0] cur, first;
    logic [15:0] w16;
    int t, w;
    bit hit;
    while (!reqReady) @(negedge clk);
    cur = m ? a : {a[18:0], 1'b0};
    first = cur;
    t = cyc + 1;
    for (int i = 0; i <= len; i++) begin
      hit = bOpen && (cur[19:4] == bTag) && (m == bMode);
      if (i == 0) w = hit ? B_FHIT : B_FMISS;
      else        w = hit ? B_PAGE : B_RAND;
      t += w;
      w16 = romWord(cur[19:1]);
      expData[tail] = m ? {8'h00, cur[0] ? w16[15:8] : w16[7:0]} : w16;
      expCyc[tail]  = t;
      expLast[tail] = (i == len);
      expTReq[tail] = (i == 0) ? (hit ? "R5" : "R3") : (hit ? "R4" : "R6");
      expDReq[tail] = m ? "R7" : "R8";
      tail = (tail + 1) % 64;
      bOpen = 1; bTag = cur[19:4]; bMode = m;
      cur = cur + (m ? 20'd1 : 20'd2);
    end
    reqValid = 1'b1;
    reqAddr  = m ? a : {1'b1, a[18:0]};   // R8: top bit is junk in word mode
    reqLen   = 5'(len);
    reqByte  = m;
    @(negedge clk);
    reqValid = 1'b0;
    chk(romAddr == first[19:1], "R2", 32'(romAddr), 32'(first[19:1]));
    chk(!romCeN && !romOeN, "R9", {30'd0, romCeN, romOeN}, 32'd0);
    if (m) begin
      chk(romAm1 == first[0] && romAm1En && !romByteN, "R7",
          {29'd0, romAm1, romAm1En, romByteN}, {29'd0, first[0], 1'b1, 1'b0});
    end else begin
      chk(!romAm1En && romByteN, "R8", {30'd0, romAm1En, romByteN}, 32'd1);
    end
    while (head != tail) @(negedge clk);
    while (!reqReady) @(negedge clk);
    chk(cyc == lastCyc + B_TURN && romOeN, "R10", 32'(cyc - lastCyc), 32'(B_TURN));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(reqReady && romCeN && romOeN && !rdValid, "R1",
        {28'd0, reqReady, romCeN, romOeN, rdValid}, 32'hE);

    // Sweep both widths, every in-page start offset, three burst lengths.
    for (int m = 0; m < 2; m++) begin
      for (int off = 0; off < (m ? 16 : 8); off++) begin
        for (int li = 0; li < 3; li++) begin
          int len;
          logic [19:0] a;
          len = (li == 0) ? 0 : ((li == 1) ? 3 : 9);
          if (m) a = 20'({16'(37 * off + 1000), 4'h0}) + 20'(off);
          else   a = 20'({16'(37 * off + 3), 3'h0}) + 20'(off);
          doBurst(m[0], a, len);
        end
      end
    end

    // R6: wrap past the top of memory in both widths.
    doBurst(1'b0, 20'h7FFFE, 3);
    doBurst(1'b1, 20'hFFFFE, 3);

    // R11: short idle keeps the page open.
    doBurst(1'b0, 20'h01230, 2);
    repeat (10) @(negedge clk);
    chk(!romCeN, "R11", 32'(romCeN), 32'd0);
    doBurst(1'b0, 20'h01233, 0);
    // R3: width change on same page is a miss.
    doBurst(1'b1, 20'h02466, 1);

    // R11: long idle enters standby and forgets the page.
    repeat (B_IDLE + B_TURN + 5) @(negedge clk);
    chk(romCeN, "R11", 32'(romCeN), 32'd1);
    chk(romOeN, "R13", 32'(romOeN), 32'd1);
    bOpen = 0;
    doBurst(1'b1, 20'h02468, 2);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule